// File: doc/BRIEF.md
# Subpath Delay Binary-Search Sequencer

This controller finds the worst-case delay of one region of subpaths. A region is the set of subpaths on one side of a test point. For each subpath it runs a binary search over a test-clock period counted in integer ticks. Every trial is one handshake with an external tester. The sequencer pulses a setup strobe and waits a fixed number of settling cycles. It then raises a trial request that carries the period. The tester answers with a done strobe and a pass bit. A pass means the observed output changed within the period.

The sequencer keeps the largest delay found so far in the region. A subpath whose smallest known passing period falls below that maximum cannot raise it, so the sequencer abandons that search early and moves on. When the last subpath is finished it pulses done and presents four results: the region maximum, the delay budget left for the complementary cone (operational period minus region maximum), the total number of trials used, and a sticky flag for any subpath that failed at the operational period.

Top module: `subpath_delay_search`

## Requirements
- R1: After reset, busy, done, trialReq and setupApply are all low.
- R2: The first trial of every subpath uses a period equal to the operational period OP_TICKS. Subpaths are tried in order 0, 1, 2…, and subpathIdx names the subpath of the current trial.
- R3: Each trial has the same sequence. setupApply pulses for one cycle. trialReq rises exactly SETTLE_CYC+1 cycles after that pulse. trialReq then stays high, with trialPeriod stable, until the cycle in which trialDone is seen.
- R4: The search keeps a failing bound `lo` (initially 0) and a passing bound `hi` (initially OP_TICKS). A pass sets hi to the trial period, and a fail sets lo to it. Each further trial uses floor((lo+hi)/2).
- R5: A subpath's search ends when hi−lo ≤ 1 or when MAX_TRIALS trials have been spent on it. Its measured delay is the final hi.
- R6: A subpath's search also ends as soon as its hi drops below the region maximum of the subpaths already finished.
- R7: If the first trial of a subpath fails, the subpath ends after that single trial. Its delay is taken as OP_TICKS, and faultSeen goes high and stays high until the next start.
- R8: After the last subpath, done pulses for exactly one cycle with busy high. At that point regionMax is the largest measured delay and budget equals OP_TICKS − regionMax.
- R9: At done, trialsUsed equals the total number of trials issued in the region.
- R10: A start with numSub = 0 issues no trial and pulses done, with regionMax 0, budget OP_TICKS and trialsUsed 0.
- R11: A start pulse while busy is ignored. The running region finishes with its own subpath count and results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a region (taken only when idle) |
| numSub | input | CW | Number of subpaths in the region |
| setupApply | output | 1 | One-cycle strobe: apply the setup vector |
| trialReq | output | 1 | Trial request: launch trigger and test clock |
| trialPeriod | output | PW | Test-clock period of the current trial, in ticks |
| subpathIdx | output | CW | Index of the subpath being tested |
| trialDone | input | 1 | Tester strobe: trial result is valid |
| trialPass | input | 1 | Output transitioned within the period |
| busy | output | 1 | Region in progress |
| done | output | 1 | One-cycle strobe: results valid |
| regionMax | output | PW | Worst-case measured delay of the region |
| budget | output | PW | OP_TICKS minus regionMax |
| trialsUsed | output | TW | Trials issued in the region |
| faultSeen | output | 1 | A subpath failed at the operational period |

## Verification
The early drop in R6 is the hardest behaviour to reach. It fires only when a later subpath is clearly faster than one already measured, and it changes nothing visible except the trial count and the periods issued. The bench models the tester with a fixed true delay per subpath. It builds regions that pair a slow subpath with fast followers and counts the trials spent on each follower. A near-exhaustive sweep of single-subpath delays, including delays above the operational period, covers every search depth and the faulty path.

// File: rtl/sds_pkg.sv
package sds_pkg;

  typedef struct packed {
    logic loadRegion;
    logic loadSub;
    logic recPass;
    logic recFail;
    logic setMid;
    logic finishSub;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SETTLE,
    ST_TRIAL,
    ST_EVAL,
    ST_FIN
  } seqState_t;

endpackage

// File: rtl/sds_datapath.sv
module sds_datapath
  import sds_pkg::*;
#(
  parameter int PW         = 8,
  parameter int CW         = 4,
  parameter int OP_TICKS   = 200,
  parameter int MAX_TRIALS = 8,
  parameter int TW         = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       ctl,
  input  logic [CW-1:0] numSub,
  output logic [PW-1:0] period,
  output logic [CW-1:0] subIdx,
  output logic [PW-1:0] regionMax,
  output logic [PW-1:0] budget,
  output logic [TW-1:0] trialsUsed,
  output logic          faultSeen,
  output logic          subDone,
  output logic          lastSub
);

  localparam int TCW = $clog2(MAX_TRIALS + 1);
  localparam logic [PW-1:0]  OP_P   = PW'(OP_TICKS);
  localparam logic [TCW-1:0] MAXT_P = TCW'(MAX_TRIALS);

  logic [PW-1:0]  lo, hi;
  logic [TCW-1:0] trialCnt;
  logic [CW-1:0]  numReg;
  logic [PW:0]    sumW;
  logic [PW-1:0]  midW;

  assign sumW = {1'b0, lo} + {1'b0, hi};
  assign midW = sumW[PW:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lo         <= '0;
      hi         <= OP_P;
      period     <= OP_P;
      trialCnt   <= '0;
      subIdx     <= '0;
      numReg     <= '0;
      regionMax  <= '0;
      trialsUsed <= '0;
      faultSeen  <= 1'b0;
    end else begin
      if (ctl.loadRegion) begin
        regionMax  <= '0;
        trialsUsed <= '0;
        subIdx     <= '0;
        faultSeen  <= 1'b0;
        numReg     <= numSub;
      end
      if (ctl.finishSub) begin
        if (hi > regionMax) regionMax <= hi;
        subIdx <= subIdx + 1'b1;
      end
      if (ctl.loadSub) begin
        lo       <= '0;
        hi       <= OP_P;
        period   <= OP_P;
        trialCnt <= '0;
      end
      if (ctl.recPass) begin
        hi         <= period;
        trialCnt   <= trialCnt + 1'b1;
        trialsUsed <= trialsUsed + 1'b1;
      end
      if (ctl.recFail) begin
        lo         <= period;
        trialCnt   <= trialCnt + 1'b1;
        trialsUsed <= trialsUsed + 1'b1;
        if (trialCnt == '0) faultSeen <= 1'b1;
      end
      if (ctl.setMid) period <= midW;
    end
  end

  always_comb begin
    subDone = ((hi - lo) <= PW'(1)) || (trialCnt == MAXT_P) || (hi < regionMax);
    lastSub = (subIdx == numReg - 1'b1);
    budget  = OP_P - regionMax;
  end

  // R5
  lo_le_hi_chk: assert property (@(posedge clk) disable iff (!rstN) lo <= hi);

  // R4
  mid_inside_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setMid |=> (period > lo) && (period < hi));

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultSeen && !ctl.loadRegion |=> faultSeen);

  // R8
  max_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    regionMax <= OP_P);

endmodule

// File: rtl/sds_control.sv
module sds_control
  import sds_pkg::*;
#(
  parameter int CW         = 4,
  parameter int SETTLE_CYC = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] numSub,
  input  logic          trialDone,
  input  logic          trialPass,
  input  logic          subDone,
  input  logic          lastSub,
  output dpCtrl_t       ctl,
  output logic          setupApply,
  output logic          trialReq,
  output logic          busy,
  output logic          done
);

  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

  seqState_t state, nextState;
  logic [SW-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      state     <= nextState;
      settleCnt <= (state == ST_SETTLE) ? settleCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.loadRegion = 1'b1;
          if (numSub == '0) begin
            nextState = ST_FIN;
          end else begin
            ctl.loadSub = 1'b1;
            nextState   = ST_SETUP;
          end
        end
      end
      ST_SETUP:  nextState = ST_SETTLE;
      ST_SETTLE: if (settleCnt == SETTLE_LAST) nextState = ST_TRIAL;
      ST_TRIAL: begin
        if (trialDone) begin
          ctl.recPass = trialPass;
          ctl.recFail = !trialPass;
          nextState   = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (subDone) begin
          ctl.finishSub = 1'b1;
          if (lastSub) begin
            nextState = ST_FIN;
          end else begin
            ctl.loadSub = 1'b1;
            nextState   = ST_SETUP;
          end
        end else begin
          ctl.setMid = 1'b1;
          nextState  = ST_SETUP;
        end
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign setupApply = (state == ST_SETUP);
  assign trialReq   = (state == ST_TRIAL);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);

  // R11
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && busy && !done |=> busy);

  // R3
  launch_after_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trialReq) |-> $past(state) == ST_SETTLE);

endmodule

// File: rtl/subpath_delay_search.sv
module subpath_delay_search
  import sds_pkg::*;
#(
  parameter int PW         = 8,
  parameter int CW         = 4,
  parameter int OP_TICKS   = 200,
  parameter int MAX_TRIALS = 8,
  parameter int SETTLE_CYC = 3,
  localparam int TW = $clog2(MAX_TRIALS * ((1 << CW) - 1) + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] numSub,
  output logic          setupApply,
  output logic          trialReq,
  output logic [PW-1:0] trialPeriod,
  output logic [CW-1:0] subpathIdx,
  input  logic          trialDone,
  input  logic          trialPass,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] regionMax,
  output logic [PW-1:0] budget,
  output logic [TW-1:0] trialsUsed,
  output logic          faultSeen
);

  dpCtrl_t ctl;
  logic    subDone, lastSub;

  sds_control #(.CW(CW), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .numSub(numSub),
    .trialDone(trialDone), .trialPass(trialPass),
    .subDone(subDone), .lastSub(lastSub), .ctl(ctl),
    .setupApply(setupApply), .trialReq(trialReq), .busy(busy), .done(done)
  );

  sds_datapath #(.PW(PW), .CW(CW), .OP_TICKS(OP_TICKS),
                 .MAX_TRIALS(MAX_TRIALS), .TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .numSub(numSub),
    .period(trialPeriod), .subIdx(subpathIdx), .regionMax(regionMax),
    .budget(budget), .trialsUsed(trialsUsed), .faultSeen(faultSeen),
    .subDone(subDone), .lastSub(lastSub)
  );

  // R3
  trial_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    trialReq && !trialDone |=> trialReq && $stable(trialPeriod));

  // R3
  setup_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    setupApply |-> !trialReq);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: tb/subpath_delay_search_tb.sv
module subpath_delay_search_tb;
  localparam int PW = 8, CW = 4, OP = 200, MAXT = 8, SET = 3;
  localparam int TW = $clog2(MAXT * ((1 << CW) - 1) + 1);

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, trialDone = 1'b0, trialPass = 1'b0;
  logic [CW-1:0] numSub = '0;
  logic setupApply, trialReq, busy, done, faultSeen;
  logic [PW-1:0] trialPeriod, regionMax, budget;
  logic [CW-1:0] subpathIdx;
  logic [TW-1:0] trialsUsed;

  subpath_delay_search #(.PW(PW), .CW(CW), .OP_TICKS(OP), .MAX_TRIALS(MAXT),
                         .SETTLE_CYC(SET)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .numSub(numSub),
    .setupApply(setupApply), .trialReq(trialReq), .trialPeriod(trialPeriod),
    .subpathIdx(subpathIdx), .trialDone(trialDone), .trialPass(trialPass),
    .busy(busy), .done(done), .regionMax(regionMax), .budget(budget),
    .trialsUsed(trialsUsed), .faultSeen(faultSeen)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  int dly [16];
  int subTr [16];
  int mLo, mHi, mCnt, mMax, mTrials, mIdx, subT;
  bit mFirst, mFault;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runRegion(input int n, input bit poke);
    int setupCyc = 0, wc = 0, prd = 0, expP;
    bit inTrial = 0, driven = 0, lastPass = 0, poked = 0, seenDone = 0;
    mLo = 0; mHi = OP; mCnt = 0; mMax = 0; mTrials = 0; mIdx = 0; subT = 0;
    mFirst = 1; mFault = 0;
    @(negedge clk); start = 1'b1; numSub = CW'(n);
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      start = 1'b0; numSub = CW'(n);
      if (trialDone) begin
        trialDone = 1'b0; trialPass = 1'b0; inTrial = 0;
        subT++; mTrials++;
        if (lastPass) mHi = prd;
        else begin mLo = prd; if (mCnt == 0) mFault = 1; end
        mCnt++;
        if (mHi - mLo <= 1 || mCnt == MAXT || mHi < mMax) begin
          subTr[mIdx] = subT;
          if (mHi > mMax) mMax = mHi;
          mIdx++; mFirst = 1; mCnt = 0; mLo = 0; mHi = OP; subT = 0;
        end
      end
      if (setupApply) setupCyc = cyc;
      if (trialReq && !inTrial) begin
        chk(cyc - setupCyc == SET + 1, "R3 settle gap", cyc - setupCyc, SET + 1);
        expP = mFirst ? OP : (mLo + mHi) / 2;
        chk(int'(trialPeriod) == expP, mFirst ? "R2 first period" : "R4 next period",
            trialPeriod, expP);
        chk(int'(subpathIdx) == mIdx, "R2 subpath index", subpathIdx, mIdx);
        mFirst = 0; inTrial = 1; driven = 0; prd = trialPeriod; wc = (prd + k) % 3;
        if (poke && !poked) begin start = 1'b1; numSub = CW'(n + 3); poked = 1; end
      end
      if (inTrial && !driven && trialReq) begin
        if (wc == 0) begin
          chk(int'(trialPeriod) == prd, "R3 period stable", trialPeriod, prd);
          lastPass = (prd >= dly[mIdx]);
          trialDone = 1'b1; trialPass = lastPass; driven = 1;
        end else wc--;
      end
      if (done) begin
        seenDone = 1;
        chk(busy, "R8 busy at done", busy, 1);
        chk(int'(regionMax) == mMax, "R8 regionMax", regionMax, mMax);
        chk(int'(budget) == OP - mMax, "R8 budget", budget, OP - mMax);
        chk(int'(trialsUsed) == mTrials, "R9 trialsUsed", trialsUsed, mTrials);
        chk(faultSeen == mFault, "R7 faultSeen", faultSeen, mFault);
        chk(mIdx == n, "R11 subpaths completed", mIdx, n);
        break;
      end
    end
    chk(seenDone, "R8 done reached", seenDone, 1);
    @(negedge clk);
    chk(!done && !busy, "R8 done one cycle", done, 0);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !trialReq && !setupApply, "R1 reset outputs",
        {busy, done, trialReq, setupApply}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5, R7: sweep of single-subpath delays, including faulty ones
    for (int d = 1; d <= OP + 6; d++) begin
      dly[0] = d;
      runRegion(1, 0);
      if (d > OP) chk(regionMax == PW'(OP), "R7 faulty delay", regionMax, OP);
    end

    // R6: slow subpath followed by a fast one
    dly[0] = 150; dly[1] = 20;
    runRegion(2, 0);
    chk(subTr[1] == 2, "R6 early drop trials", subTr[1], 2);

    // R6: later subpaths both faster and slower
    dly[0] = 60; dly[1] = 180; dly[2] = 90; dly[3] = 10;
    runRegion(4, 0);
    chk(subTr[3] == 2, "R6 drop after max 180", subTr[3], 2);

    // R7: faulty subpath first, then a normal one
    dly[0] = 250; dly[1] = 40;
    runRegion(2, 0);
    chk(subTr[0] == 1, "R7 single trial on fault", subTr[0], 1);

    // R10: empty region
    runRegion(0, 0);
    chk(trialsUsed == '0 && budget == PW'(OP), "R10 empty region", trialsUsed, 0);

    // R11: start while busy
    dly[0] = 70; dly[1] = 120;
    runRegion(2, 1);

    // full-size region
    for (int i = 0; i < 15; i++) dly[i] = (i * 37 + 13) % 199 + 1;
    runRegion(15, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule